// File: doc/BRIEF.md
# Queued SPI Master with Selectable Attribute Sets

This block is a synchronous, full-duplex SPI master that works from a queue of transfer commands. Each command carries a data word, a six-bit chip-select pattern, a three-bit index that picks one of six stored clock/transfer attribute sets, and a continuous-select bit. The selected attribute set gives the clock polarity, the clock phase, the frame size (4 to 16 bits) and the SCK half-period. Commands wait in a four-entry transmit FIFO. Received frames go into a four-entry receive FIFO.

The engine is a five-state machine. IDLE holds the bus quiet and takes the head command when the queue is non-empty (IDLE→LEAD). LEAD asserts the chip-selects for one half-period before the first clock edge (LEAD→SHIFT). SHIFT runs two half-periods per bit. After the last half it pushes the received word (SHIFT→TRAIL). TRAIL keeps the chip-selects asserted for one half-period with SCK at rest. Two exits follow from TRAIL:
- If the frame asked for continuous select and another command is queued, it takes that command straight away (TRAIL→LEAD).
- Otherwise it releases the chip-selects (TRAIL→GAP). GAP holds them released for one half-period before returning (GAP→IDLE).

The six attribute sets come in on a flat configuration vector, ten bits per set. Set k occupies bits [10k+9:10k]. Within a set:
- bit 0 is the clock polarity;
- bit 1 is the clock phase;
- bits 5:2 hold the frame size minus one;
- bits 9:6 hold the half-period divisor.

Top module: `spim_master`

## Requirements
- R1: After reset cs_n is 6'h3F, sck is 0, cmd_ready is 1, rx_valid is 0, eot is 0 and rx_ovf is 0.
- R2: Each frame of N bits shifts the low N bits of the command data out on mosi MSB first. In the same frame it shifts N bits in from miso, MSB first. The received word appears in rx_data right-justified, with zeros above bit N-1.
- R3: Frame size is N = field+1, where the field is bits 5:2 of the set. Field values 0, 1 and 2 give 4-bit frames.
- R4: Bit 0 of a set is the SCK rest level (polarity). Bit 1 is the phase.
  - Phase 0: the master samples miso on the first edge of each bit and changes mosi on the second.
  - Phase 1: mosi changes on the first edge of each bit and miso is sampled on the second.
- R5: Every SCK half-period within a frame lasts div+1 clock cycles, where div is bits 9:6 of the selected set.
- R6: During a frame cs_n equals the bitwise inverse of the command's chip-select pattern.
- R7: Set index values 0 to 5 select that set. Values 6 and 7 select set 0.
- R8: When a frame's continuous-select bit is 1 and another command is queued at its end, cs_n stays asserted between the two frames.
- R9: When the continuous-select bit is 0, cs_n returns to 6'h3F between consecutive frames.
- R10: The transmit FIFO holds 4 commands beyond the one in progress. cmd_ready is 0 while it is full, and a command offered while it is full is discarded.
- R11: eot rises when a frame ends with no command queued. It clears on the cycle after a command is accepted.
- R12: The receive FIFO holds 4 words. A frame that ends while it is full sets rx_ovf and its word is dropped. rx_ovf clears when a word is popped.
- R13: While no frame is in progress, cs_n is 6'h3F and sck stays at the polarity of the last frame's set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| attr_cfg | input | 60 | Six attribute sets, 10 bits each |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Transmit FIFO has room |
| cmd_data | input | 16 | Transmit word, right-justified |
| cmd_cs | input | 6 | Chip-select pattern, 1 = asserted |
| cmd_set | input | 3 | Attribute set index |
| cmd_cont | input | 1 | Continuous select after this frame |
| rx_pop | input | 1 | Remove the head receive word |
| rx_valid | output | 1 | Receive FIFO not empty |
| rx_data | output | 16 | Head receive word |
| rx_ovf | output | 1 | Receive overflow flag |
| eot | output | 1 | Queued sequence complete |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 6 | Active-low chip-selects |

## Verification
The bench uses a bit-accurate slave model that follows the SCK edges. The transfer path is driven under all four polarity/phase pairs, so a swapped sampling edge or a flipped rest level corrupts one of the words in both directions. Frame sizes 4, 5, 8, 12 and 16 are run, with asymmetric data patterns. An undersized frame-size field and out-of-range set indices show whether clamping and default selection work. Back-to-back pairs with and without continuous select separate chip-select hold from release. A burst of five long frames with no receive pops fills both FIFOs, which exposes full-queue rejection, overflow dropping and the flag clearing.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int SPIM_DW   = 16;
    localparam int SPIM_CSW  = 6;
    localparam int SPIM_NSET = 6;
    localparam int SPIM_SELW = 3;
    localparam int SPIM_DIVW = 4;
    localparam int SPIM_FSW  = 4;
    localparam int SPIM_MINF = 3;   // smallest frame-size-minus-one

    typedef struct packed {
        logic [SPIM_DIVW-1:0] div;
        logic [SPIM_FSW-1:0]  fsz_m1;
        logic                 cpha;
        logic                 cpol;
    } spim_attr_t;

    localparam int SPIM_ATTR_W = $bits(spim_attr_t);

    typedef struct packed {
        logic                 cont;
        logic [SPIM_SELW-1:0] sel;
        logic [SPIM_CSW-1:0]  cs;
        logic [SPIM_DW-1:0]   data;
    } spim_cmd_t;

    localparam int SPIM_CMD_W = $bits(spim_cmd_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL,
        ST_GAP
    } spim_state_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    a_r10_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    a_r10_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);
endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [SPIM_NSET*SPIM_ATTR_W-1:0] attr_cfg,
    input  spim_cmd_t                       head,
    input  logic                            tx_empty,
    input  logic                            cmd_push,
    input  logic                            miso,
    output logic                            tx_pop,
    output logic                            rx_push,
    output logic [SPIM_DW-1:0]              rx_word,
    output logic                            sck,
    output logic                            mosi,
    output logic [SPIM_CSW-1:0]             cs_n,
    output logic                            eot
);
    logic [SPIM_ATTR_W-1:0] tbl [SPIM_NSET];

    for (genvar g = 0; g < SPIM_NSET; g++) begin : g_tbl
        assign tbl[g] = attr_cfg[g*SPIM_ATTR_W +: SPIM_ATTR_W];
    end

    spim_state_t           state, nxt;
    spim_attr_t            pick, cur;
    logic [SPIM_DIVW-1:0]  cnt;
    logic [SPIM_FSW:0]     half;
    logic [SPIM_DW-1:0]    sh_tx, sh_rx;
    logic [SPIM_CSW-1:0]   cs_r;
    logic                  cont_r, sck_r, eot_r;
    logic                  tick, last_half, take, done, fin;

    // attribute selection with default set and frame-size floor
    always_comb begin
        pick = spim_attr_t'(tbl[0]);
        for (int k = 1; k < SPIM_NSET; k++) begin
            if (head.sel == SPIM_SELW'(k)) pick = spim_attr_t'(tbl[k]);
        end
        if (pick.fsz_m1 < SPIM_FSW'(SPIM_MINF)) pick.fsz_m1 = SPIM_FSW'(SPIM_MINF);
    end

    assign tick      = (cnt == '0);
    assign last_half = (half == {cur.fsz_m1, 1'b1});

    // next-state decisions
    always_comb begin
        nxt  = state;
        take = 1'b0;
        done = 1'b0;
        fin  = 1'b0;
        unique case (state)
            ST_IDLE:  if (!tx_empty) begin take = 1'b1; nxt = ST_LEAD; end
            ST_LEAD:  if (tick) nxt = ST_SHIFT;
            ST_SHIFT: if (tick && last_half) begin done = 1'b1; nxt = ST_TRAIL; end
            ST_TRAIL: if (tick) begin
                if (cont_r && !tx_empty) begin take = 1'b1; nxt = ST_LEAD; end
                else begin fin = 1'b1; nxt = ST_GAP; end
            end
            ST_GAP:   if (tick) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur    <= '0;
            cnt    <= '0;
            half   <= '0;
            sh_tx  <= '0;
            sh_rx  <= '0;
            cs_r   <= '0;
            cont_r <= 1'b0;
            sck_r  <= 1'b0;
            eot_r  <= 1'b0;
        end else begin
            if (take) begin
                cur    <= pick;
                cs_r   <= head.cs;
                cont_r <= head.cont;
                sh_tx  <= head.data << (SPIM_FSW'(SPIM_DW-1) - pick.fsz_m1);
                sh_rx  <= '0;
                cnt    <= pick.div;
                sck_r  <= pick.cpol;
            end else if (state != ST_IDLE) begin
                cnt <= tick ? cur.div : cnt - 1'b1;
            end
            if (state == ST_LEAD && tick) begin
                half  <= '0;
                sck_r <= cur.cpol ^ cur.cpha;
            end
            if (state == ST_SHIFT && tick) begin
                if (!half[0]) sh_rx <= {sh_rx[SPIM_DW-2:0], miso};
                else          sh_tx <= sh_tx << 1;
                if (last_half) sck_r <= cur.cpol;
                else begin
                    half  <= half + 1'b1;
                    sck_r <= ~sck_r;
                end
            end
            if (fin) cs_r <= '0;
            if (fin && tx_empty) eot_r <= 1'b1;
            else if (cmd_push)   eot_r <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        tx_pop  = take;
        rx_push = done;
        rx_word = sh_rx;
        sck     = sck_r;
        mosi    = sh_tx[SPIM_DW-1];
        cs_n    = ~cs_r;
        eot     = eot_r;
    end

    a_r6_cs_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (cs_n == '1));
    a_r13_sck_rests: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE) |-> $stable(sck));
    a_r2_half_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> (half <= {cur.fsz_m1, 1'b1}));
    a_r3_min_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (cur.fsz_m1 >= SPIM_FSW'(SPIM_MINF)));
    a_r8_cont_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEAD && $past(state) == ST_TRAIL) |-> $past(cont_r));
    a_r11_eot_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eot) |-> ($past(state) == ST_TRAIL && $past(tx_empty)));
endmodule

// File: rtl/spim_master.sv
module spim_master
    import spim_pkg::*;
#(
    parameter int TX_DEPTH = 4,
    parameter int RX_DEPTH = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [SPIM_NSET*SPIM_ATTR_W-1:0] attr_cfg,
    input  logic                             cmd_valid,
    output logic                             cmd_ready,
    input  logic [SPIM_DW-1:0]               cmd_data,
    input  logic [SPIM_CSW-1:0]              cmd_cs,
    input  logic [SPIM_SELW-1:0]             cmd_set,
    input  logic                             cmd_cont,
    input  logic                             rx_pop,
    output logic                             rx_valid,
    output logic [SPIM_DW-1:0]               rx_data,
    output logic                             rx_ovf,
    output logic                             eot,
    output logic                             sck,
    output logic                             mosi,
    input  logic                             miso,
    output logic [SPIM_CSW-1:0]              cs_n
);
    spim_cmd_t          in_cmd, head;
    logic               tx_full, tx_empty, tx_pop, cmd_push;
    logic               rx_full, rx_empty, rx_push;
    logic [SPIM_DW-1:0] rx_word;
    logic               ovf_r;

    assign in_cmd    = '{cont: cmd_cont, sel: cmd_set, cs: cmd_cs, data: cmd_data};
    assign cmd_ready = !tx_full;
    assign cmd_push  = cmd_valid && !tx_full;
    assign rx_valid  = !rx_empty;
    assign rx_ovf    = ovf_r;

    spim_fifo #(.W(SPIM_CMD_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(cmd_valid), .wdata(in_cmd),
        .pop(tx_pop), .rdata(head),
        .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.W(SPIM_DW), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .wdata(rx_word),
        .pop(rx_pop), .rdata(rx_data),
        .full(rx_full), .empty(rx_empty)
    );

    spim_engine u_eng (
        .clk(clk), .rst_n(rst_n),
        .attr_cfg(attr_cfg), .head(head),
        .tx_empty(tx_empty), .cmd_push(cmd_push), .miso(miso),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
        .sck(sck), .mosi(mosi), .cs_n(cs_n), .eot(eot)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      ovf_r <= 1'b0;
        else if (rx_push && rx_full)     ovf_r <= 1'b1;
        else if (rx_pop && !rx_empty)    ovf_r <= 1'b0;
    end

    a_r12_ovf_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovf) |-> $past(rx_full));
endmodule

// File: tb/tb_spim_master.sv
`timescale 1ns/1ps
module tb_spim_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [59:0] attr_cfg = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [15:0] cmd_data = '0;
    logic [5:0]  cmd_cs = '0;
    logic [2:0]  cmd_set = '0;
    logic        cmd_cont = 1'b0;
    logic        rx_pop = 1'b0;
    logic        rx_valid;
    logic [15:0] rx_data;
    logic        rx_ovf, eot, sck, mosi;
    logic        miso = 1'b0;
    logic [5:0]  cs_n;

    spim_master dut (
        .clk(clk), .rst_n(rst_n), .attr_cfg(attr_cfg),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .cmd_cs(cmd_cs), .cmd_set(cmd_set), .cmd_cont(cmd_cont),
        .rx_pop(rx_pop), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ovf(rx_ovf), .eot(eot), .sck(sck), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // slave model state
    int          slv_n = 8;
    bit          slv_cpha = 1'b0;
    logic [15:0] slv_words [8];
    int          slv_idx = 0;
    logic [15:0] got [8];
    int          got_cnt = 0, edge_cnt = 0, last_edge = 0;
    int          hl_min = 9999, hl_max = 0, cs_falls = 0;
    logic [15:0] acc = '0;
    logic [5:0]  seen_cs = '1;
    logic        sck_q = 1'b0, cs_q = 1'b0;

    function automatic logic sbit(int k);
        return slv_words[slv_idx & 7][slv_n - 1 - k];
    endfunction

    always @(negedge clk) begin
        logic cs_now;
        cs_now = (cs_n != 6'h3F);
        if (cs_now && !cs_q) begin
            cs_falls++;
            edge_cnt = 0;
            acc = '0;
            seen_cs = cs_n;
            if (!slv_cpha) miso = sbit(0);
        end else if (cs_now && sck != sck_q) begin
            edge_cnt++;
            if (edge_cnt > 1) begin
                if (cyc - last_edge < hl_min) hl_min = cyc - last_edge;
                if (cyc - last_edge > hl_max) hl_max = cyc - last_edge;
            end
            last_edge = cyc;
            if (slv_cpha ? (edge_cnt % 2 == 0) : (edge_cnt % 2 == 1))
                acc = {acc[14:0], mosi};
            if (!slv_cpha && edge_cnt % 2 == 0 && edge_cnt < 2*slv_n)
                miso = sbit(edge_cnt / 2);
            if (slv_cpha && edge_cnt % 2 == 1)
                miso = sbit((edge_cnt - 1) / 2);
            if (edge_cnt == 2*slv_n) begin
                got[got_cnt & 7] = acc;
                got_cnt++;
                slv_idx++;
                edge_cnt = 0;
                acc = '0;
                if (!slv_cpha) miso = sbit(0);
            end
        end
        sck_q = sck;
        cs_q = cs_now;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [9:0] mk(bit cpol, bit cpha, int fsz_m1, int div);
        return {4'(div), 4'(fsz_m1), cpha, cpol};
    endfunction

    task automatic push(input logic [15:0] d, input logic [5:0] cs,
                        input logic [2:0] s, input bit cont);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_data = d; cmd_cs = cs; cmd_set = s; cmd_cont = cont;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_eot(input string req);
        int t = 0;
        while (!eot && t < 20000) begin @(negedge clk); t++; end
        chk(eot, req, "eot after sequence", eot, 1);
    endtask

    task automatic pop_check(input int exp, input string req);
        @(negedge clk);
        chk(rx_valid && rx_data == 16'(exp), req, "rx word", rx_data, exp);
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic arm(input int n, input bit cpha);
        slv_n = n; slv_cpha = cpha; slv_idx = 0; got_cnt = 0;
        hl_min = 9999; hl_max = 0; cs_falls = 0;
    endtask

    task automatic t_reset;
        chk(cs_n == 6'h3F && sck == 1'b0, "R1", "bus at reset", {cs_n, sck}, 7'h7E);
        chk(cmd_ready && !rx_valid, "R1", "queues at reset", {cmd_ready, rx_valid}, 2'b10);
        chk(!eot && !rx_ovf, "R1", "flags at reset", {eot, rx_ovf}, 0);
    endtask

    task automatic t_frame(input int s, input int n, input bit cpol, input bit cpha,
                           input int div, input logic [15:0] d, input logic [15:0] sw,
                           input logic [5:0] cs, input string req);
        int mask = (1 << n) - 1;
        arm(n, cpha);
        slv_words[0] = sw;
        push(d, cs, 3'(s), 1'b0);
        chk(!eot, "R11", "eot cleared by push", eot, 0);
        wait_eot(req);
        chk(got_cnt == 1 && got[0] == 16'(d & mask), req, "R2 mosi word", got[0], d & mask);
        chk(hl_min == div + 1 && hl_max == div + 1, "R5", "half period", hl_max, div + 1);
        chk(seen_cs == ~cs, "R6", "cs pattern", seen_cs, ~cs);
        chk(sck == cpol && cs_n == 6'h3F, "R13", "rest state (R4 polarity)", {cs_n, sck}, {6'h3F, cpol});
        pop_check(sw & mask, req);
    endtask

    task automatic t_pair(input bit cont, input string req);
        arm(8, 1'b0);
        slv_words[0] = 16'h81; slv_words[1] = 16'h7E;
        push(16'h55, 6'b000010, 3'd0, cont);
        push(16'hC1, 6'b000010, 3'd0, 1'b0);
        wait_eot(req);
        chk(cs_falls == (cont ? 1 : 2), req, "select assertions", cs_falls, cont ? 1 : 2);
        chk(got_cnt == 2 && got[0] == 16'h55 && got[1] == 16'hC1, req, "pair mosi", got[1], 16'hC1);
        pop_check(16'h81, req);
        pop_check(16'h7E, req);
    endtask

    task automatic t_burst;
        arm(12, 1'b1);
        for (int i = 0; i < 5; i++) slv_words[i] = 16'(16'h101 * (i + 3));
        for (int i = 0; i < 5; i++) push(16'(16'h0A1 + i), 6'b001000, 3'd2, 1'b0);
        chk(!cmd_ready, "R10", "ready low when full", cmd_ready, 0);
        cmd_valid = 1'b1; cmd_data = 16'hFFF; cmd_set = 3'd2; cmd_cs = 6'b001000;
        repeat (2) @(negedge clk);
        cmd_valid = 1'b0;
        wait_eot("R10");
        chk(got_cnt == 5, "R10", "frames sent", got_cnt, 5);
        chk(got[4] == 16'h0A5, "R10", "last frame data", got[4], 16'h0A5);
        chk(rx_ovf, "R12", "overflow flag set", rx_ovf, 1);
        pop_check(16'h303, "R12");
        chk(!rx_ovf, "R12", "overflow cleared by pop", rx_ovf, 0);
        for (int i = 1; i < 4; i++) pop_check(16'(16'h101 * (i + 3)) & 16'hFFF, "R12");
        @(negedge clk);
        chk(!rx_valid, "R12", "fifth word dropped", rx_valid, 0);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected 0 cycles left", cyc);
        finish_run();
    end

    initial begin
        attr_cfg = {mk(0,1,4,0), mk(0,0,1,0), mk(1,1,3,3), mk(0,1,11,2), mk(1,0,15,0), mk(0,0,7,1)};
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_frame(0, 8, 0, 0, 1, 16'h00A5, 16'h003C, 6'b000001, "R2");
        t_frame(1, 16, 1, 0, 0, 16'h1234, 16'hBEEF, 6'b100000, "R4");
        t_frame(2, 12, 0, 1, 2, 16'h0ABC, 16'h05A3, 6'b010101, "R4");
        t_frame(3, 4, 1, 1, 3, 16'h0009, 16'h0006, 6'b111111, "R4");
        t_frame(4, 4, 0, 0, 0, 16'h00F7, 16'h00AD, 6'b000100, "R3");
        t_frame(5, 5, 0, 1, 0, 16'h0013, 16'h000A, 6'b011000, "R2");
        t_frame(7, 8, 0, 0, 1, 16'h01C3, 16'h0099, 6'b000011, "R7");
        t_frame(6, 8, 0, 0, 1, 16'h005E, 16'h00E1, 6'b110000, "R7");
        t_pair(1'b1, "R8");
        t_pair(1'b0, "R9");
        t_burst();
        finish_run();
    end
endmodule